// File: doc/BRIEF.md
# Multi-Queue Dual-Clock FIFO with Per-Port Queue Selection

This block divides one shared dual-port memory into sixteen independent first-in first-out queues of 18-bit words. A write port and a read port run on separate clocks. Each port picks its active queue on its own by pulsing a select strobe together with a 7-bit address. The write port reports, through an active-low full flag, whether the queue it reports on can take another word. The read port presents the head word of its queue in fall-through style and marks it with an output-valid flag.

Switching queues takes time on both ports. On the write side, the full flag goes on describing the old queue for a short while after a switch. On the read side, one more word of the old queue is pushed out before the new queue's first word is presented. Neither of these steps needs a read enable. Several copies can share the two buses. Each copy has a device number, acts only on selections that carry its own number, and drives its flag enables only while it is selected.

Top module: `mq_flow_fifo`

## Requirements
- R1: Each of the 16 queues keeps its words in write order, independently of the others; a queue holds `DEPTH` words (default 16).
- R2: A port's selection takes effect on a clock edge where its select strobe is high; address bits [6:4] carry the device number and bits [3:0] the queue number (e.g. 7'b001_1100 is device 1, queue 12).
- R3: After a write-port selection edge, `full_n` keeps showing the previous queue until the next write clock edge; after that second edge it shows the newly selected queue.
- R4: The write that fills the last free word drives `full_n` low; a write enable (`wr_en_n` low) on an edge where `full_n` is low stores nothing.
- R5: A write-port selection is accepted while `full_n` is low, with no write needed.
- R6: On the first read edge after a read-port selection edge, one more word of the previous queue is loaded to `rd_data`. On the second edge, word 0 of the new queue is loaded. Both happen whatever the level of `rd_en_n`.
- R7: After that, `rd_data` advances only on edges where `rd_en_n` is low; with `rd_en_n` high it holds its word.
- R8: A word leaving a queue makes it not full; for the write-selected queue, `full_n` rises two write clock edges after the read edge that removed the word.
- R9: A word written into an empty queue selected on both ports reaches `rd_data` with `out_valid` high after the third read edge following the write edge. `out_valid` drops when the last word has been consumed.
- R10: `full_oe` (and `out_oe` on the read side) is high only while its port selects this copy's `DEV_ID`; writes and reads aimed at another device do not touch this copy's queues.
- R11: After reset both ports select device 0 queue 0, all queues are empty, `out_valid` is low, `rd_data` is zero and `full_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-port clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| wq_sel | input | 1 | Write-port queue select strobe |
| wq_adr | input | 7 | Write-port device and queue address |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 18 | Word to store |
| full_n | output | 1 | Full flag of the reported queue, low when full |
| full_oe | output | 1 | Enable for `full_n`, high while this device owns the write port |
| rclk | input | 1 | Read-port clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| rq_sel | input | 1 | Read-port queue select strobe |
| rq_adr | input | 7 | Read-port device and queue address |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | 18 | Presented head word |
| out_valid | output | 1 | High while `rd_data` holds a valid word |
| out_oe | output | 1 | Enable for the read outputs, high while this device owns the read port |

## Verification
If a per-queue pointer holds a wrong value, the effect shows at the ports within a few cycles. Words come out of a queue in the wrong order or from the wrong queue, a flag stays high after a drained queue, or `full_n` falls one word early or late. A fault in the synchronizer stage count moves the first-word arrival and the full-flag release by whole cycles, so the bench samples at the exact edge counts of R8 and R9. A fault in the switch sequencing shows on the next two read edges after a selection, as a missing or extra word from the old queue.

// File: rtl/mq_pkg.sv
`timescale 1ns/1ps
package mq_pkg;
    localparam int QID_W = 4;
    localparam int DEV_W = 3;
    localparam int ADR_W = QID_W + DEV_W;
    localparam int NQ    = 1 << QID_W;

    typedef struct packed {
        logic [DEV_W-1:0] dev;
        logic [QID_W-1:0] qid;
    } qsel_t;

    typedef enum logic [1:0] {
        RD_RUN   = 2'd0,
        RD_FLUSH = 2'd1,
        RD_LOAD  = 2'd2
    } rd_phase_t;

    function automatic logic [15:0] bin_to_gray(input logic [15:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [15:0] gray_to_bin(input logic [15:0] g);
        logic [15:0] r;
        r[15] = g[15];
        for (int i = 14; i >= 0; i--) r[i] = r[i+1] ^ g[i];
        return r;
    endfunction
endpackage

// File: rtl/mq_gray_sync.sv
`timescale 1ns/1ps
module mq_gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/mq_store.sv
`timescale 1ns/1ps
module mq_store #(
    parameter int WIDTH = 18,
    parameter int AW    = 8
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rclk,
    input  logic             rrst,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [WIDTH-1:0] mem [WORDS];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rrst)    rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/mq_wr_ctrl.sv
`timescale 1ns/1ps
module mq_wr_ctrl
    import mq_pkg::*;
#(
    parameter int WIDTH  = 18,
    parameter int DEPTH  = 16,
    parameter int DEV_ID = 0,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sel,
    input  logic [ADR_W-1:0]          adr,
    input  logic                      en_n,
    input  logic [WIDTH-1:0]          data,
    input  logic [NQ-1:0][PW-1:0]     rsync,
    output logic [NQ-1:0][PW-1:0]     wgray,
    output logic                      mem_we,
    output logic [QID_W+AW-1:0]       mem_waddr,
    output logic [WIDTH-1:0]          mem_wdata,
    output logic                      full_n,
    output logic                      full_oe
);
    localparam logic [PW-1:0] FULL_OCC = PW'(DEPTH);

    qsel_t                 a;
    logic [QID_W-1:0]      cur_q;
    logic [QID_W-1:0]      flag_q;
    logic                  mine;
    logic [NQ-1:0][PW-1:0] wbin;
    logic [NQ-1:0]         qfull;
    logic [PW-1:0]         occ_cur;
    logic [PW-1:0]         wnext;
    logic                  wr_ok;

    assign a = qsel_t'(adr);

    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            qfull[q] = (wbin[q] - PW'(gray_to_bin(16'(rsync[q])))) == FULL_OCC;
        end
    end

    assign occ_cur   = wbin[cur_q] - PW'(gray_to_bin(16'(rsync[cur_q])));
    assign full_n    = !qfull[flag_q];
    assign full_oe   = mine;
    assign wr_ok     = !en_n && mine && full_n && !qfull[cur_q];
    assign wnext     = wbin[cur_q] + 1'b1;
    assign mem_we    = wr_ok;
    assign mem_waddr = {cur_q, wbin[cur_q][AW-1:0]};
    assign mem_wdata = data;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            flag_q <= '0;
            mine   <= (DEV_ID == 0);
            wbin   <= '0;
            wgray  <= '0;
        end else begin
            flag_q <= cur_q;
            if (sel) begin
                cur_q <= a.qid;
                mine  <= (a.dev == DEV_W'(DEV_ID));
            end
            if (wr_ok) begin
                wbin[cur_q]  <= wnext;
                wgray[cur_q] <= PW'(bin_to_gray(16'(wnext)));
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ_cur <= FULL_OCC) else $error("queue overfilled"); // R4

    AST_FLAG_LAGS_SELECT: assert property (@(posedge clk) disable iff (rst)
        (sel && !$past(sel)) |=> $stable(flag_q)) else $error("flag switched early"); // R3
endmodule

// File: rtl/mq_rd_ctrl.sv
`timescale 1ns/1ps
module mq_rd_ctrl
    import mq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DEV_ID = 0,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sel,
    input  logic [ADR_W-1:0]          adr,
    input  logic                      en_n,
    input  logic [NQ-1:0][PW-1:0]     wsync,
    output logic [NQ-1:0][PW-1:0]     rgray,
    output logic                      mem_re,
    output logic [QID_W+AW-1:0]       mem_raddr,
    output logic                      out_valid,
    output logic                      out_oe
);
    localparam logic [PW-1:0] FULL_OCC = PW'(DEPTH);

    qsel_t                 a;
    logic [QID_W-1:0]      cur_q, prev_q, tq;
    logic                  mine, prev_mine, tmine;
    rd_phase_t             phase;
    logic                  ov;
    logic [NQ-1:0][PW-1:0] rbin;
    logic [NQ-1:0]         qempty;
    logic                  want, avail, load;
    logic [PW-1:0]         rnext;
    logic [PW-1:0]         occ_cur;

    assign a = qsel_t'(adr);

    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            qempty[q] = rbin[q] == PW'(gray_to_bin(16'(wsync[q])));
        end
    end

    always_comb begin
        tq    = cur_q;
        tmine = mine;
        want  = 1'b0;
        unique case (phase)
            RD_FLUSH: begin
                tq    = prev_q;
                tmine = prev_mine;
                want  = 1'b1;
            end
            RD_LOAD: want = 1'b1;
            default: want = !ov || !en_n;
        endcase
        avail = tmine && !qempty[tq];
        load  = want && avail;
    end

    assign rnext     = rbin[tq] + 1'b1;
    assign mem_re    = load;
    assign mem_raddr = {tq, rbin[tq][AW-1:0]};
    assign out_valid = ov;
    assign out_oe    = mine;
    assign occ_cur   = PW'(gray_to_bin(16'(wsync[cur_q]))) - rbin[cur_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= '0;
            prev_q    <= '0;
            mine      <= (DEV_ID == 0);
            prev_mine <= (DEV_ID == 0);
            phase     <= RD_RUN;
            ov        <= 1'b0;
            rbin      <= '0;
            rgray     <= '0;
        end else begin
            if (sel) begin
                prev_q    <= cur_q;
                prev_mine <= mine;
                cur_q     <= a.qid;
                mine      <= (a.dev == DEV_W'(DEV_ID));
                phase     <= RD_FLUSH;
            end else if (phase == RD_FLUSH) begin
                phase <= RD_LOAD;
            end else if (phase == RD_LOAD) begin
                phase <= RD_RUN;
            end
            if (load) begin
                rbin[tq]  <= rnext;
                rgray[tq] <= PW'(bin_to_gray(16'(rnext)));
                ov        <= 1'b1;
            end else if (want) begin
                ov <= 1'b0;
            end
        end
    end

    AST_FLUSH_THEN_LOAD: assert property (@(posedge clk) disable iff (rst)
        (phase == RD_FLUSH && !sel) |=> (phase == RD_LOAD)) else $error("switch order broken"); // R6

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ_cur <= FULL_OCC) else $error("read passed write pointer"); // R1
endmodule

// File: rtl/mq_flow_fifo.sv
`timescale 1ns/1ps
module mq_flow_fifo
    import mq_pkg::*;
#(
    parameter int WIDTH  = 18,
    parameter int DEPTH  = 16,
    parameter int DEV_ID = 0
) (
    input  logic             wclk,
    input  logic             wrst,
    input  logic             wq_sel,
    input  logic [6:0]       wq_adr,
    input  logic             wr_en_n,
    input  logic [WIDTH-1:0] wr_data,
    output logic             full_n,
    output logic             full_oe,
    input  logic             rclk,
    input  logic             rrst,
    input  logic             rq_sel,
    input  logic [6:0]       rq_adr,
    input  logic             rd_en_n,
    output logic [WIDTH-1:0] rd_data,
    output logic             out_valid,
    output logic             out_oe
);
    localparam int AW  = $clog2(DEPTH);
    localparam int PW  = AW + 1;
    localparam int MAW = QID_W + AW;

    logic [NQ-1:0][PW-1:0] wgray, wsync, rgray, rsync;
    logic                  mem_we, mem_re;
    logic [MAW-1:0]        mem_waddr, mem_raddr;
    logic [WIDTH-1:0]      mem_wdata;

    mq_wr_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .DEV_ID(DEV_ID)) wr_i (
        .clk(wclk), .rst(wrst), .sel(wq_sel), .adr(wq_adr), .en_n(wr_en_n),
        .data(wr_data), .rsync(rsync), .wgray(wgray), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .full_n(full_n),
        .full_oe(full_oe)
    );

    mq_rd_ctrl #(.DEPTH(DEPTH), .DEV_ID(DEV_ID)) rd_i (
        .clk(rclk), .rst(rrst), .sel(rq_sel), .adr(rq_adr), .en_n(rd_en_n),
        .wsync(wsync), .rgray(rgray), .mem_re(mem_re), .mem_raddr(mem_raddr),
        .out_valid(out_valid), .out_oe(out_oe)
    );

    mq_store #(.WIDTH(WIDTH), .AW(MAW)) store_i (
        .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .rclk(rclk), .rrst(rrst), .re(mem_re), .raddr(mem_raddr), .rdata(rd_data)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_cross
        mq_gray_sync #(.W(PW)) w2r_i (.clk(rclk), .rst(rrst), .d(wgray[q]), .q(wsync[q]));
        mq_gray_sync #(.W(PW)) r2w_i (.clk(wclk), .rst(wrst), .d(rgray[q]), .q(rsync[q]));
    end

    AST_HOLD_WITHOUT_ENABLE: assert property (@(posedge rclk) disable iff (rrst)
        (rd_en_n && out_valid && !rq_sel && !$past(rq_sel) && !$past(rq_sel, 2))
        |=> $stable(rd_data)) else $error("output moved without enable"); // R7

    AST_OE_FOLLOWS_SELECT: assert property (@(posedge wclk) disable iff (wrst)
        $past(wq_sel) |-> (full_oe == ($past(wq_adr[6:4]) == DEV_W'(DEV_ID))))
        else $error("flag enable wrong"); // R10
endmodule

// File: tb/mq_flow_fifo_tb_top.sv
`timescale 1ns/1ps
module mq_flow_fifo_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wq_sel, wr_en_n, rq_sel, rd_en_n;
    logic [6:0]  wq_adr, rq_adr;
    logic [17:0] wr_data;
    logic        full_n, full_oe, out_valid, out_oe;
    logic [17:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mq_flow_fifo #(.WIDTH(18), .DEPTH(16), .DEV_ID(1)) dut_i (
        .wclk(clk), .wrst(rst), .wq_sel(wq_sel), .wq_adr(wq_adr),
        .wr_en_n(wr_en_n), .wr_data(wr_data), .full_n(full_n), .full_oe(full_oe),
        .rclk(clk), .rrst(rst), .rq_sel(rq_sel), .rq_adr(rq_adr),
        .rd_en_n(rd_en_n), .rd_data(rd_data), .out_valid(out_valid), .out_oe(out_oe)
    );

    // {queue[3:0], data[17:0]}
    localparam logic [21:0] VEC [12] = '{
        {4'd3,  18'h00311}, {4'd3,  18'h00322}, {4'd3,  18'h00333},
        {4'd12, 18'h3C001}, {4'd12, 18'h3C002}, {4'd12, 18'h3C003},
        {4'd12, 18'h3C004}, {4'd2,  18'h20002}, {4'd2,  18'h12345},
        {4'd2,  18'h3FFFF}, {4'd3,  18'h00344}, {4'd3,  18'h00000}
    };

    logic [17:0] exp_w [16][16];
    int          cnt   [16];

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wsel(input logic [2:0] dev, input logic [3:0] q);
        wq_sel = 1'b1; wq_adr = {dev, q};
        tick();
        wq_sel = 1'b0;
    endtask

    task automatic rsel(input logic [2:0] dev, input logic [3:0] q);
        rq_sel = 1'b1; rq_adr = {dev, q};
        tick();
        rq_sel = 1'b0;
    endtask

    task automatic wput(input logic [17:0] d);
        wr_en_n = 1'b0; wr_data = d;
        tick();
        wr_en_n = 1'b1;
    endtask

    task automatic rpop();
        rd_en_n = 1'b0;
        tick();
        rd_en_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int curq;
        int rq_list [3];
        rq_list = '{2, 3, 12};
        rst = 1'b1; wq_sel = 0; wr_en_n = 1; rq_sel = 0; rd_en_n = 1;
        wq_adr = '0; rq_adr = '0; wr_data = '0;
        for (int q = 0; q < 16; q++) cnt[q] = 0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R11: reset state (device 0 selected, this copy is device 1)
        check("R11 full_oe", 32'(full_oe), 32'd0);
        check("R11 out_oe", 32'(out_oe), 32'd0);
        check("R11 out_valid", 32'(out_valid), 32'd0);
        check("R11 full_n", 32'(full_n), 32'd1);
        check("R11 rd_data", 32'(rd_data), 32'd0);

        // R1 R2: table of writes spread over queues 3, 12 and 2
        curq = -1;
        for (int i = 0; i < 12; i++) begin
            int q;
            q = int'(VEC[i][21:18]);
            if (q != curq) begin
                wsel(3'd1, 4'(q));
                tick();
                curq = q;
            end
            wput(VEC[i][17:0]);
            exp_w[q][cnt[q]] = VEC[i][17:0];
            cnt[q]++;
        end
        repeat (4) tick();

        for (int k = 0; k < 3; k++) begin
            int q;
            q = rq_list[k];
            rsel(3'd1, 4'(q));
            tick();
            tick();
            check("R1 R2 first word", 32'(rd_data), 32'(exp_w[q][0]));
            check("R1 R2 valid", 32'(out_valid), 32'd1);
            for (int j = 1; j < cnt[q]; j++) begin
                rpop();
                check("R1 R2 order", 32'(rd_data), 32'(exp_w[q][j]));
            end
            rpop();
            check("R9 drained", 32'(out_valid), 32'd0);
        end

        // R9: first-word latency with queue 5 on both ports
        wsel(3'd1, 4'd5);
        rsel(3'd1, 4'd5);
        repeat (3) tick();
        wput(18'h2A5A5);
        tick();
        tick();
        check("R9 not yet valid", 32'(out_valid), 32'd0);
        tick();
        check("R9 valid after three edges", 32'(out_valid), 32'd1);
        check("R9 data", 32'(rd_data), 32'h2A5A5);
        rpop();
        check("R9 last word consumed", 32'(out_valid), 32'd0);

        // R4: fill queue 5 with the read port parked on queue 7
        rsel(3'd1, 4'd7);
        repeat (3) tick();
        for (int i = 0; i < 15; i++) wput(18'h100 + 18'(i));
        check("R4 not full at 15", 32'(full_n), 32'd1);
        wput(18'h10F);
        check("R4 full at 16", 32'(full_n), 32'd0);
        wput(18'h3ABCD);
        check("R4 still full", 32'(full_n), 32'd0);

        // R3 R5: select empty queue 6 while full; write during lag is dropped
        wsel(3'd1, 4'd6);
        check("R3 flag still old queue", 32'(full_n), 32'd0);
        wput(18'h00155);
        check("R5 R3 flag shows new queue", 32'(full_n), 32'd1);

        // R8: read from full queue 5 releases the flag two edges later
        wsel(3'd1, 4'd5);
        tick();
        check("R3 flag on full queue 5", 32'(full_n), 32'd0);
        rsel(3'd1, 4'd5);
        tick();
        tick();
        check("R6 word0 without enable", 32'(rd_data), 32'h100);
        check("R6 valid", 32'(out_valid), 32'd1);
        tick();
        check("R8 not yet released", 32'(full_n), 32'd0);
        tick();
        check("R8 released", 32'(full_n), 32'd1);

        // R6 R7: switch read port from queue 5 to queue 6
        wsel(3'd1, 4'd6);
        tick();
        wput(18'h000B0);
        wput(18'h000B1);
        repeat (4) tick();
        rsel(3'd1, 4'd6);
        check("R6 old word held on select edge", 32'(rd_data), 32'h100);
        tick();
        check("R6 one more old word", 32'(rd_data), 32'h101);
        tick();
        check("R6 R4 new queue word0", 32'(rd_data), 32'h000B0);
        tick();
        tick();
        check("R7 held without enable", 32'(rd_data), 32'h000B0);
        rpop();
        check("R7 advance on enable", 32'(rd_data), 32'h000B1);
        rpop();
        check("R9 empty after last", 32'(out_valid), 32'd0);

        // R10: another device on the write and read ports
        wsel(3'd2, 4'd9);
        check("R10 full_oe released", 32'(full_oe), 32'd0);
        wput(18'h000DD);
        wsel(3'd1, 4'd9);
        check("R10 full_oe driven", 32'(full_oe), 32'd1);
        rsel(3'd2, 4'd9);
        check("R10 out_oe released", 32'(out_oe), 32'd0);
        rsel(3'd1, 4'd9);
        repeat (3) tick();
        check("R10 out_oe driven", 32'(out_oe), 32'd1);
        check("R10 foreign write ignored", 32'(out_valid), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule